// File: doc/BRIEF.md
# Image block rasterizer

The block sits in front of a block-based compression network. A greyscale image arrives as a raster stream of 8-bit grey levels, one pixel per accepted beat, top line first and left to right within a line. The block cuts the image into square tiles of 2, 4, 8 or 16 pixels on a side. It emits each tile as a vector of N = side² samples, and each sample is the grey level scaled into the unit interval as an unsigned 16-bit fraction.

Incoming lines are written into one of two banks. Each bank holds a strip of tiles, which is side-length lines of up to the maximum width. While one full strip is read out tile by tile, the next strip fills the other bank. Input stalls only when both banks hold strips that have not been emitted.

Both streams use valid/ready, and a beat transfers on a rising clock edge where both are high. The block drops `in_ready` only when both banks are full or the configuration is invalid. `out_valid` stays high, with sample and markers unchanged, until `out_ready` takes the beat. The configuration inputs are plain levels. They must be stable whenever reset is released, and they may change only while reset is held.

Top module: `blk_raster`

## Requirements
- R1: Every output sample equals the source grey level p times 257, an unsigned fraction with 16 fractional bits: 0 gives 0, 128 gives 32896 and 255 gives 65535.
- R2: `cfg_bsel` selects the tile side: 0 gives 2, 1 gives 4, 2 gives 8 and 3 gives 16. A frame of W x H yields (W/side)·(H/side) vectors of side² samples each.
- R3: Within a tile, samples follow row-major order: the top tile row left to right, then each row below it.
- R4: Tiles are emitted left to right across a strip, and strips from top to bottom.
- R5: `out_sov` is high on the first sample of each vector only, and `out_eov` is high on the N-th sample only. The beat after an end-of-vector beat starts a new vector.
- R6: The configuration is invalid when the width or height is zero, when either is not a multiple of the tile side, or when the width exceeds `MAX_W`. An invalid configuration raises `cfg_err`, holds `in_ready` low and produces no output.
- R7: While `out_valid` is high and `out_ready` is low, the sample and both markers stay unchanged.
- R8: Input is accepted while the previous strip is being emitted. With the output stalled, exactly two strips (2·side·W pixels) are accepted before `in_ready` falls, and `in_ready` is low only when both banks are full.
- R9: After reset with a valid configuration, `in_ready` is high, `out_valid` is low and `cfg_err` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_width | input | $clog2(MAX_W+1) (6) | Image width in pixels |
| cfg_height | input | $clog2(MAX_H+1) (11) | Image height in lines |
| cfg_bsel | input | 2 | Tile side select: 0:2, 1:4, 2:8, 3:16 |
| cfg_err | output | 1 | Configuration invalid, nothing processed |
| in_valid | input | 1 | Pixel beat offered |
| in_ready | output | 1 | Pixel beat can be taken |
| in_pix | input | 8 | Grey level 0..255 |
| out_valid | output | 1 | Sample beat offered |
| out_ready | input | 1 | Sample beat taken by the sink |
| out_sample | output | 16 | Normalised sample, unsigned fraction |
| out_sov | output | 1 | First sample of a vector |
| out_eov | output | 1 | Last (N-th) sample of a vector |

## Verification
The assertions assume that the configuration changes only while reset is held. The end-of-vector count and the both-banks-full stall check rest on that assumption. The bench applies each configuration before it releases reset and resets again before each new scenario. The pixel source keeps its own beat until it sees `in_ready`, as the stream rules require. The sink drops `out_ready` only in whole cycles, so the held-output check sees a clean stall.

// File: rtl/blk_pkg.sv
`timescale 1ns/1ps
package blk_pkg;
  localparam int unsigned PIX_W  = 8;
  localparam int unsigned SMP_W  = 16;
  localparam int unsigned MAX_BS = 16;
  localparam int unsigned LINE_W = $clog2(MAX_BS);
  localparam int unsigned BS_W   = LINE_W + 1;

  typedef enum logic [1:0] {
    SIDE2  = 2'd0,
    SIDE4  = 2'd1,
    SIDE8  = 2'd2,
    SIDE16 = 2'd3
  } side_sel_e;

  function automatic logic [BS_W-1:0] side_of(input logic [1:0] sel);
    side_of = BS_W'(2) << sel;
  endfunction
endpackage

// File: rtl/blk_cfg_check.sv
`timescale 1ns/1ps
module blk_cfg_check #(
  parameter int unsigned MAX_W = 32,
  parameter int unsigned MAX_H = 1024,
  localparam int unsigned WW   = $clog2(MAX_W + 1),
  localparam int unsigned HW   = $clog2(MAX_H + 1),
  localparam int unsigned BS_W = blk_pkg::BS_W
) (
  input  logic [WW-1:0]   width,
  input  logic [HW-1:0]   height,
  input  logic [1:0]      bsel,
  output logic [BS_W-1:0] side,
  output logic            err
);
  logic [WW-1:0] wmask;
  logic [HW-1:0] hmask;

  always_comb begin
    side  = blk_pkg::side_of(bsel);
    wmask = WW'(side) - WW'(1);
    hmask = HW'(side) - HW'(1);
    err   = (width == '0) || (height == '0) ||
            (width > WW'(MAX_W)) ||
            ((width & wmask) != '0) || ((height & hmask) != '0);
  end
endmodule

// File: rtl/blk_writer.sv
`timescale 1ns/1ps
module blk_writer #(
  parameter int unsigned MAX_W = 32,
  localparam int unsigned WW     = $clog2(MAX_W + 1),
  localparam int unsigned COL_W  = $clog2(MAX_W),
  localparam int unsigned LINE_W = blk_pkg::LINE_W,
  localparam int unsigned BS_W   = blk_pkg::BS_W,
  localparam int unsigned ADDR_W = 1 + LINE_W + COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [WW-1:0]     width,
  input  logic [BS_W-1:0]   side,
  input  logic [1:0]        full_q,
  input  logic              in_valid,
  output logic              in_ready,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              strip_done,
  output logic              wb
);
  logic [COL_W-1:0]  col_q;
  logic [LINE_W-1:0] line_q;
  logic              wb_q;
  logic              last_col, last_line;

  assign in_ready   = en && !full_q[wb_q];
  assign wr_en      = in_valid && in_ready;
  assign last_col   = (WW'(col_q) == width - WW'(1));
  assign last_line  = (BS_W'(line_q) == side - BS_W'(1));
  assign strip_done = wr_en && last_col && last_line;
  assign wr_addr    = {wb_q, line_q, col_q};
  assign wb         = wb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q  <= '0;
      line_q <= '0;
      wb_q   <= 1'b0;
    end else if (wr_en) begin
      if (last_col) begin
        col_q <= '0;
        if (last_line) begin
          line_q <= '0;
          wb_q   <= ~wb_q;
        end else begin
          line_q <= line_q + LINE_W'(1);
        end
      end else begin
        col_q <= col_q + COL_W'(1);
      end
    end
  end

  // R4
  col_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (WW'(col_q) < width));
endmodule

// File: rtl/blk_reader.sv
`timescale 1ns/1ps
module blk_reader #(
  parameter int unsigned MAX_W = 32,
  localparam int unsigned WW     = $clog2(MAX_W + 1),
  localparam int unsigned COL_W  = $clog2(MAX_W),
  localparam int unsigned LINE_W = blk_pkg::LINE_W,
  localparam int unsigned BS_W   = blk_pkg::BS_W,
  localparam int unsigned ADDR_W = 1 + LINE_W + COL_W,
  localparam int unsigned CNT_W  = 2 * LINE_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WW-1:0]     width,
  input  logic [BS_W-1:0]   side,
  input  logic [1:0]        full_q,
  input  logic              out_ready,
  output logic              out_valid,
  output logic              out_sov,
  output logic              out_eov,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              strip_done,
  output logic              rb
);
  logic             rb_q;
  logic [COL_W-1:0] bx_q;
  logic [LINE_W-1:0] r_q, c_q;
  logic             fire, last_c, last_r, last_b;
  logic [COL_W-1:0] col;

  assign out_valid  = full_q[rb_q];
  assign fire       = out_valid && out_ready;
  assign last_c     = (BS_W'(c_q) == side - BS_W'(1));
  assign last_r     = (BS_W'(r_q) == side - BS_W'(1));
  assign last_b     = (WW'(bx_q) + WW'(side) == width);
  assign col        = bx_q + COL_W'(c_q);
  assign rd_addr    = {rb_q, r_q, col};
  assign out_sov    = out_valid && (c_q == '0) && (r_q == '0);
  assign out_eov    = out_valid && last_c && last_r;
  assign strip_done = fire && last_c && last_r && last_b;
  assign rb         = rb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rb_q <= 1'b0;
      bx_q <= '0;
      r_q  <= '0;
      c_q  <= '0;
    end else if (fire) begin
      if (!last_c) begin
        c_q <= c_q + LINE_W'(1);
      end else begin
        c_q <= '0;
        if (!last_r) begin
          r_q <= r_q + LINE_W'(1);
        end else begin
          r_q <= '0;
          if (last_b) begin
            bx_q <= '0;
            rb_q <= ~rb_q;
          end else begin
            bx_q <= bx_q + COL_W'(side);
          end
        end
      end
    end
  end

  // beats since the last end of vector, kept for the marker check
  logic [CNT_W-1:0] beat_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                beat_q <= '0;
    else if (fire && out_eov)  beat_q <= '0;
    else if (fire)             beat_q <= beat_q + CNT_W'(1);
  end

  // R5
  eov_on_nth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_eov |-> (beat_q == CNT_W'(side) * CNT_W'(side) - CNT_W'(1)));
  // R5
  sov_after_eov_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && out_eov) |=> (!out_valid || out_sov));
  // R7
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(rd_addr) &&
                                   $stable(out_sov) && $stable(out_eov)));
endmodule

// File: rtl/blk_norm.sv
`timescale 1ns/1ps
module blk_norm #(
  localparam int unsigned PIX_W = blk_pkg::PIX_W,
  localparam int unsigned SMP_W = blk_pkg::SMP_W
) (
  input  logic [PIX_W-1:0] pix,
  output logic [SMP_W-1:0] smp
);
  // p/255 in a 16-bit fraction: p*65535/255 = p*257, exact for every p
  assign smp = SMP_W'(pix) * SMP_W'(257);
endmodule

// File: rtl/blk_raster.sv
`timescale 1ns/1ps
module blk_raster #(
  parameter int unsigned MAX_W = 32,
  parameter int unsigned MAX_H = 1024,
  localparam int unsigned WW     = $clog2(MAX_W + 1),
  localparam int unsigned HW     = $clog2(MAX_H + 1),
  localparam int unsigned COL_W  = $clog2(MAX_W),
  localparam int unsigned PIX_W  = blk_pkg::PIX_W,
  localparam int unsigned SMP_W  = blk_pkg::SMP_W,
  localparam int unsigned BS_W   = blk_pkg::BS_W,
  localparam int unsigned ADDR_W = 1 + blk_pkg::LINE_W + COL_W,
  localparam int unsigned DEPTH  = 1 << ADDR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WW-1:0]    cfg_width,
  input  logic [HW-1:0]    cfg_height,
  input  logic [1:0]       cfg_bsel,
  output logic             cfg_err,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PIX_W-1:0] in_pix,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [SMP_W-1:0] out_sample,
  output logic             out_sov,
  output logic             out_eov
);
  logic [BS_W-1:0]   side;
  logic [1:0]        full_q;
  logic              wr_en, wr_done, wb, rd_done, rb;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [PIX_W-1:0]  rd_pix;
  logic [PIX_W-1:0]  mem [DEPTH];

  blk_cfg_check #(.MAX_W(MAX_W), .MAX_H(MAX_H)) cfg_i (
    .width(cfg_width), .height(cfg_height), .bsel(cfg_bsel),
    .side(side), .err(cfg_err));

  blk_writer #(.MAX_W(MAX_W)) wr_i (
    .clk(clk), .rst_n(rst_n), .en(!cfg_err), .width(cfg_width),
    .side(side), .full_q(full_q), .in_valid(in_valid),
    .in_ready(in_ready), .wr_en(wr_en), .wr_addr(wr_addr),
    .strip_done(wr_done), .wb(wb));

  blk_reader #(.MAX_W(MAX_W)) rd_i (
    .clk(clk), .rst_n(rst_n), .width(cfg_width), .side(side),
    .full_q(full_q), .out_ready(out_ready), .out_valid(out_valid),
    .out_sov(out_sov), .out_eov(out_eov), .rd_addr(rd_addr),
    .strip_done(rd_done), .rb(rb));

  blk_norm norm_i (.pix(rd_pix), .smp(out_sample));

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= in_pix;
  end
  assign rd_pix = mem[rd_addr];

  // bank occupancy: writer sets its bank, reader clears its own
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= '0;
    end else begin
      if (wr_done) full_q[wb] <= 1'b1;
      if (rd_done) full_q[rb] <= 1'b0;
    end
  end

  // R8
  stall_both_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_err && !in_ready) |-> (full_q == 2'b11));
  // R6
  err_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (!out_valid && !wr_en));
  // R8
  banks_distinct_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_done && rd_done) |-> (wb != rb));
endmodule

// File: tb/blk_raster_tb_top.sv
`timescale 1ns/1ps
module blk_raster_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  cfg_width = 6'd8;
  logic [10:0] cfg_height = 11'd8;
  logic [1:0]  cfg_bsel = 2'd0;
  logic        cfg_err;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_pix = 8'd0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [15:0] out_sample;
  logic        out_sov, out_eov;

  int checks = 0;
  int failures = 0;
  int acc_cnt = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  blk_raster dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width), .cfg_height(cfg_height),
    .cfg_bsel(cfg_bsel), .cfg_err(cfg_err), .in_valid(in_valid),
    .in_ready(in_ready), .in_pix(in_pix), .out_valid(out_valid),
    .out_ready(out_ready), .out_sample(out_sample), .out_sov(out_sov),
    .out_eov(out_eov));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pixval(input int mode, input int x, input int y, input int seed);
    if (mode == 1) begin
      case (x + 2 * y)
        0: return 8'd0;
        1: return 8'd255;
        2: return 8'd128;
        default: return 8'd1;
      endcase
    end
    return 8'((x * 7 + y * 29 + seed * 13) & 255);
  endfunction

  task automatic do_reset(input int w, input int h, input int sel);
    in_valid = 1'b0;
    out_ready = 1'b0;
    rst_n = 1'b0;
    cfg_width = 6'(w);
    cfg_height = 11'(h);
    cfg_bsel = 2'(sel);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic drive(input int w, input int h, input int mode, input int seed);
    for (int y = 0; y < h; y++) begin
      for (int x = 0; x < w; x++) begin
        @(negedge clk);
        in_valid = 1'b1;
        in_pix = pixval(mode, x, y, seed);
        while (!in_ready) @(negedge clk);
        acc_cnt++;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // stall: 0 = sink always ready, 1 = sink drops ready every third cycle
  task automatic collect(input int w, input int h, input int sel, input int mode,
                         input int seed, input int stall);
    int bs, nvec, cyc, bad_d, bad_m;
    bs = 2 << sel;
    nvec = 0; cyc = 0; bad_d = 0; bad_m = 0;
    for (int br = 0; br < h / bs; br++)
      for (int bc = 0; bc < w / bs; bc++)
        for (int r = 0; r < bs; r++)
          for (int c = 0; c < bs; c++) begin
            logic [15:0] exp_s;
            forever begin
              @(negedge clk);
              out_ready = (stall == 0) || (cyc % 3 != 0);
              cyc++;
              if (out_valid && out_ready) break;
            end
            exp_s = 16'(pixval(mode, bc * bs + c, br * bs + r, seed)) * 16'd257;
            if (out_sample != exp_s) begin
              bad_d++;
              chk(1'b0, "R1/R3/R4 sample value", int'(out_sample), int'(exp_s));
            end
            if (out_sov != (r == 0 && c == 0) || out_eov != (r == bs - 1 && c == bs - 1)) begin
              bad_m++;
              chk(1'b0, "R5 vector markers", int'({out_sov, out_eov}),
                  int'({r == 0 && c == 0, r == bs - 1 && c == bs - 1}));
            end
            if (out_sov) nvec++;
          end
    chk(bad_d == 0, "R3/R4 tile order and values", bad_d, 0);
    chk(bad_m == 0, "R5 start/end markers", bad_m, 0);
    chk(nvec == (w / bs) * (h / bs), "R2 vector count", nvec, (w / bs) * (h / bs));
    @(negedge clk);
    chk(!out_valid, "R2 no extra samples", int'(out_valid), 0);
  endtask

  task automatic run_frame(input int w, input int h, input int sel, input int mode,
                           input int seed, input int stall);
    do_reset(w, h, sel);
    acc_cnt = 0;
    fork
      drive(w, h, mode, seed);
      collect(w, h, sel, mode, seed, stall);
    join
    chk(acc_cnt == w * h, "R8 all pixels accepted", acc_cnt, w * h);
  endtask

  task automatic test_reset();
    do_reset(16, 16, 1);
    chk(in_ready == 1'b1, "R9 in_ready after reset", int'(in_ready), 1);
    chk(out_valid == 1'b0, "R9 out_valid after reset", int'(out_valid), 0);
    chk(cfg_err == 1'b0, "R9 cfg_err after reset", int'(cfg_err), 0);
  endtask

  task automatic test_norm_extremes();
    // R1: 0, 255, 128, 1 give 0, 65535, 32896, 257
    run_frame(2, 2, 0, 1, 0, 0);
  endtask

  task automatic test_backpressure();
    logic [15:0] held;
    logic held_sov;
    do_reset(8, 8, 0);
    acc_cnt = 0;
    fork
      drive(8, 8, 0, 5);
      begin
        repeat (80) @(negedge clk);
        chk(acc_cnt == 32, "R8 two strips accepted under stall", acc_cnt, 32);
        chk(in_ready == 1'b0, "R8 input stalled when both full", int'(in_ready), 0);
        chk(out_valid == 1'b1, "R7 output offered while stalled", int'(out_valid), 1);
        held = out_sample;
        held_sov = out_sov;
        repeat (5) @(negedge clk);
        chk(out_sample == held, "R7 sample held under stall", int'(out_sample), int'(held));
        chk(out_sov == held_sov && out_sov, "R7 marker held under stall", int'(out_sov), 1);
        collect(8, 8, 0, 0, 5, 0);
      end
    join
    chk(acc_cnt == 64, "R8 input resumes after drain", acc_cnt, 64);
  endtask

  task automatic try_bad(input int w, input int h, input int sel, input string why);
    int seen;
    do_reset(w, h, sel);
    seen = 0;
    chk(cfg_err == 1'b1, {"R6 cfg_err ", why}, int'(cfg_err), 1);
    chk(in_ready == 1'b0, {"R6 in_ready low ", why}, int'(in_ready), 0);
    in_valid = 1'b1;
    in_pix = 8'd200;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (out_valid || in_ready) seen++;
    end
    in_valid = 1'b0;
    chk(seen == 0, {"R6 nothing processed ", why}, seen, 0);
  endtask

  task automatic test_errors();
    try_bad(12, 8, 2, "width not multiple");
    try_bad(8, 6, 2, "height not multiple");
    try_bad(0, 8, 0, "zero width");
    try_bad(48, 16, 3, "width over max");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    test_reset();
    test_norm_extremes();
    run_frame(16, 8, 0, 0, 1, 0);   // R2 side 2
    run_frame(32, 16, 1, 0, 2, 0);  // R2 side 4
    run_frame(32, 32, 2, 0, 3, 1);  // R2 side 8, sink stalls
    run_frame(32, 16, 3, 0, 4, 1);  // R2 side 16, sink stalls
    test_backpressure();
    test_errors();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule